// File: doc/BRIEF.md
# Descriptor-Driven Configuration Transfer Engine

This engine moves bytes out of a keyed configuration item store into system memory with no per-byte host access. The host writes the memory address of a 16-byte descriptor into an 8-byte register window. The engine then fetches the descriptor over a simple memory master port. If the descriptor asks for it, the engine selects a new item. It then copies item bytes to the target buffer or skips over them, and finally records the outcome by overwriting the descriptor's control word in memory.

The descriptor is big-endian throughout. Bytes 0..7 hold the target address, bytes 8..11 the length and bytes 12..15 the control word. Control bit 1 requests a copy, bit 2 requests a skip and bit 3 requests a select, in which case bits 31:16 carry the new key. Bit 0 is the error flag in the status that is written back. The item store keeps the key and the read offset. The engine tells the store when to load a key (which also zeroes the offset) and by how much to advance the offset, and the store presents the item length, the current offset and the item bytes starting at that offset.

Top module: `cfg_dma_engine`

## Requirements
- R1: The register window decodes three writes. A 4-byte write at offset 0 sets the latched address to {data[31:0], 32'h0}. A 4-byte write at offset 4 ORs data[31:0] into the low half and starts a transfer. An 8-byte write at offset 0 loads the full address and starts a transfer. Any other write size or offset raises reg_err_o in that cycle and has no effect.
- R2: A read of size 1, 2, 4 or 8 at offset a, with a plus size at most 8, returns in the low bits of reg_rdata_o the size-byte big-endian slice of SIGNATURE that starts at byte a (byte 0 is bits 63:56). Any other read returns zero and raises reg_err_o.
- R3: The latched address is cleared to zero when a transfer starts, so a later start by a lone 4-byte write at offset 4 fetches exactly the written low word.
- R4: The descriptor is fetched as one 16-byte read at the latched address and decoded with the big-endian layout above.
- R5: With control bit 3 set, the engine loads key control[31:16] into the store, which zeroes the offset, before any data moves.
- R6: Copy (bit 1) takes priority over skip (bit 2). With neither bit set the length is treated as zero, and only the status write happens.
- R7: In copy mode, while item bytes remain, each burst writes the next item bytes to the target. Its size is the smallest of the remaining length, the bytes left in the item and MAX_BURST, and the item offset then advances by that size.
- R8: In skip mode, item bytes are consumed by advancing the offset without any memory write other than the status write.
- R9: Once the item is invalid, empty or exhausted, the remaining length is consumed without changing the offset. In copy mode that span is filled with zero bytes in bursts of at most MAX_BURST.
- R10: An error response on a data burst stops the transfer without advancing the offset, and the status becomes 1. An error on the descriptor fetch skips all data movement, and the status becomes 1.
- R11: The 32-bit status (0 on success, 1 on error) is written big-endian as a 4-byte write at descriptor address plus 8, and busy_o falls once that write is acknowledged.
- R12: While busy_o is high, every register write is rejected with reg_err_o and does not start a transfer.
- R13: Every memory write carries a length from 1 to MAX_BURST, and a request holds its address and length until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register window write strobe |
| reg_rd_i | input | 1 | Register window read strobe |
| reg_addr_i | input | 3 | Byte offset in the window |
| reg_size_i | input | 4 | Access size in bytes |
| reg_wdata_i | input | 64 | Write data, right-aligned |
| reg_rdata_o | output | 64 | Read data, right-aligned |
| reg_err_o | output | 1 | Access rejected |
| busy_o | output | 1 | Transfer in progress |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 64 | Byte address |
| mem_len_o | output | 5 | Bytes in the request |
| mem_wdata_o | output | 8*MAX_BURST | Write bytes, byte i at bits 8i+7:8i |
| mem_rdata_i | input | 128 | Read bytes, byte i at bits 8i+7:8i |
| mem_ack_i | input | 1 | Request completed |
| mem_err_i | input | 1 | Error response, valid with ack |
| key_load_o | output | 1 | Store loads key and zeroes offset |
| key_o | output | 16 | Key to load |
| off_inc_o | output | 1 | Store advances offset |
| off_step_o | output | 32 | Offset advance amount |
| item_ok_i | input | 1 | Selected item exists and is non-empty |
| item_len_i | input | 32 | Selected item length |
| item_off_i | input | 32 | Current offset |
| item_data_i | input | 8*MAX_BURST | Item bytes from current offset |

## Verification
The hardest case to reach is a copy transfer that runs off the end of an item in the middle of a request. There, one part of the span comes from item data in bursts capped by both the item remainder and MAX_BURST, and the rest is zero-filled while the offset stays put. The stimulus reaches it by drawing lengths larger than the bytes left in short items, and by chaining transfers without a select, so that later transfers start part-way into an item or past its end. Error responses are produced by placing targets and descriptors in a faulting address range of the memory model, and the busy lockout is probed by a start write issued one cycle after a transfer has begun.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SEL, ST_XFER, ST_WB
  } dma_st_e;

  localparam int CTL_ERR  = 0;
  localparam int CTL_COPY = 1;
  localparam int CTL_SKIP = 2;
  localparam int CTL_SEL  = 3;

  localparam int DESC_BYTES = 16;
endpackage

// File: rtl/cfg_dma_regwin.sv
module cfg_dma_regwin #(
  parameter logic [63:0] SIGNATURE = 64'h4346_475F_444D_4131
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [2:0]  addr_i,
  input  logic [3:0]  size_i,
  input  logic [63:0] wdata_i,
  input  logic        busy_i,
  output logic [63:0] rdata_o,
  output logic        err_o,
  output logic        start_o,
  output logic [63:0] desc_o
);
  logic [63:0] addr_q;
  logic hi_wr, lo_wr, full_wr, wr_legal, wr_ok;
  logic size_legal, rd_ok;
  logic [4:0] span;
  logic [6:0] sh;
  logic [63:0] msk;

  assign hi_wr    = size_i == 4'd4 && addr_i == 3'd0;
  assign lo_wr    = size_i == 4'd4 && addr_i == 3'd4;
  assign full_wr  = size_i == 4'd8 && addr_i == 3'd0;
  assign wr_legal = hi_wr | lo_wr | full_wr;
  assign wr_ok    = wr_i && wr_legal && !busy_i;
  assign start_o  = wr_ok && (lo_wr || full_wr);
  assign desc_o   = full_wr ? wdata_i : (addr_q | {32'h0, wdata_i[31:0]});

  always_comb begin
    span       = 5'(addr_i) + 5'(size_i);
    size_legal = size_i inside {4'd1, 4'd2, 4'd4, 4'd8};
    rd_ok      = size_legal && span <= 5'd8;
    sh         = rd_ok ? 7'({5'd8 - span, 3'b000}) : 7'd0;
    msk        = (size_i == 4'd8) ? '1 : ((64'd1 << {size_i, 3'b000}) - 64'd1);
    rdata_o    = (rd_i && rd_ok) ? ((SIGNATURE >> sh) & msk) : '0;
    err_o      = (wr_i && (!wr_legal || busy_i)) || (rd_i && !rd_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 addr_q <= '0;
    else if (start_o)            addr_q <= '0;
    else if (wr_ok && hi_wr)     addr_q <= {wdata_i[31:0], 32'h0};
  end

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> addr_q == '0); // R3
endmodule

// File: rtl/cfg_dma_chunker.sv
module cfg_dma_chunker #(
  parameter int MAX_BURST = 8
) (
  input  logic        copy_i,
  input  logic [31:0] rem_i,
  input  logic        item_ok_i,
  input  logic [31:0] item_len_i,
  input  logic [31:0] item_off_i,
  output logic        has_data_o,
  output logic [31:0] n_o
);
  localparam logic [31:0] BURST = 32'(MAX_BURST);
  logic [31:0] avail, lim;

  always_comb begin
    avail      = (item_ok_i && item_off_i < item_len_i) ? item_len_i - item_off_i : '0;
    has_data_o = avail != '0;
    lim        = has_data_o ? ((rem_i < avail) ? rem_i : avail) : rem_i;
    if (copy_i && lim > BURST) n_o = BURST;
    else                       n_o = lim;
  end
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
#(
  parameter int          MAX_BURST = 8,
  parameter logic [63:0] SIGNATURE = 64'h4346_475F_444D_4131,
  localparam int         DW        = 8 * MAX_BURST,
  localparam int         LEN_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [3:0]        reg_size_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              reg_err_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [63:0]       mem_addr_o,
  output logic [LEN_W-1:0]  mem_len_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [127:0]      mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  output logic              key_load_o,
  output logic [15:0]       key_o,
  output logic              off_inc_o,
  output logic [31:0]       off_step_o,
  input  logic              item_ok_i,
  input  logic [31:0]       item_len_i,
  input  logic [31:0]       item_off_i,
  input  logic [DW-1:0]     item_data_i
);
  dma_st_e     st_q, st_d;
  logic [63:0] desc_q, tgt_q, start_desc;
  logic [31:0] rem_q, ctl_q;
  logic        copy_q, stat_err_q, start;
  logic [63:0] fld_addr;
  logic [31:0] fld_len, fld_ctl;
  logic        ck_has;
  logic [31:0] ck_n;

  cfg_dma_regwin #(.SIGNATURE(SIGNATURE)) u_regwin (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i), .size_i(reg_size_i),
    .wdata_i(reg_wdata_i), .busy_i(busy_o), .rdata_o(reg_rdata_o),
    .err_o(reg_err_o), .start_o(start), .desc_o(start_desc)
  );

  cfg_dma_chunker #(.MAX_BURST(MAX_BURST)) u_chunker (
    .copy_i(copy_q), .rem_i(rem_q), .item_ok_i, .item_len_i, .item_off_i,
    .has_data_o(ck_has), .n_o(ck_n)
  );

  // big-endian descriptor decode, memory byte i at rdata[8i+:8]
  always_comb begin
    for (int i = 0; i < 8; i++) fld_addr[63-8*i -: 8] = mem_rdata_i[8*i +: 8];
    for (int i = 0; i < 4; i++) begin
      fld_len[31-8*i -: 8] = mem_rdata_i[8*(8+i) +: 8];
      fld_ctl[31-8*i -: 8] = mem_rdata_i[8*(12+i) +: 8];
    end
  end

  assign busy_o     = st_q != ST_IDLE;
  assign key_o      = ctl_q[31:16];
  assign off_step_o = ck_n;

  always_comb begin
    st_d        = st_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_q;
    mem_len_o   = LEN_W'(DESC_BYTES);
    mem_wdata_o = '0;
    key_load_o  = 1'b0;
    off_inc_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_FETCH;
      ST_FETCH: begin
        mem_req_o = 1'b1;
        if (mem_ack_i)
          st_d = mem_err_i ? ST_WB : (fld_ctl[CTL_SEL] ? ST_SEL : ST_XFER);
      end
      ST_SEL: begin
        key_load_o = 1'b1;
        st_d       = ST_XFER;
      end
      ST_XFER: begin
        if (rem_q == '0) st_d = ST_WB;
        else if (copy_q) begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = tgt_q;
          mem_len_o   = ck_n[LEN_W-1:0];
          mem_wdata_o = ck_has ? item_data_i : '0;
          if (mem_ack_i) begin
            if (mem_err_i) st_d = ST_WB;
            else           off_inc_o = ck_has;
          end
        end else off_inc_o = ck_has;
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q + 64'd8;
        mem_len_o   = LEN_W'(4);
        mem_wdata_o = DW'({stat_err_q, 24'h0}); // status byte 3 = LSB of word
        if (mem_ack_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      desc_q     <= '0;
      tgt_q      <= '0;
      rem_q      <= '0;
      ctl_q      <= '0;
      copy_q     <= 1'b0;
      stat_err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        ST_IDLE: if (start) begin
          desc_q     <= start_desc;
          stat_err_q <= 1'b0;
        end
        ST_FETCH: if (mem_ack_i) begin
          if (mem_err_i) stat_err_q <= 1'b1;
          else begin
            tgt_q  <= fld_addr;
            ctl_q  <= fld_ctl;
            copy_q <= fld_ctl[CTL_COPY];
            rem_q  <= (fld_ctl[CTL_COPY] || fld_ctl[CTL_SKIP]) ? fld_len : '0;
          end
        end
        ST_XFER: if (rem_q != '0) begin
          if (!copy_q) rem_q <= rem_q - ck_n;
          else if (mem_ack_i) begin
            if (mem_err_i) stat_err_q <= 1'b1;
            else begin
              rem_q <= rem_q - ck_n;
              tgt_q <= tgt_q + 64'(ck_n);
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_BURST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_len_o != '0 && 32'(mem_len_o) <= 32'(MAX_BURST)); // R13
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_len_o)); // R13
  AST_OFF_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_inc_o |-> item_ok_i && item_off_i < item_len_i
                  && off_step_o != '0 && off_step_o <= item_len_i - item_off_i); // R7
  AST_WB_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i && mem_len_o == LEN_W'(4))); // R11
endmodule

// File: tb/cfg_dma_engine_tb.sv
module cfg_dma_engine_tb;
  localparam int          MAXB   = 8;
  localparam int          DW     = 8 * MAXB;
  localparam logic [63:0] TB_SIG = 64'h1122_3344_5566_7788;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [3:0]  reg_size = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic        reg_err, busy;
  logic        mem_req, mem_we, mem_ack = 0, mem_err = 0;
  logic [63:0] mem_addr;
  logic [4:0]  mem_len;
  logic [DW-1:0] mem_wdata, item_data;
  logic [127:0] mem_rdata = '0;
  logic        key_load, off_inc;
  logic [15:0] key;
  logic [31:0] off_step;
  logic [15:0] sk;
  logic [31:0] so;

  int errors = 0, checks = 0, nwr = 0, burst_bad = 0, dly = 0;
  logic [63:0] fetch_addr = '0;
  logic [7:0] mem [0:2047];
  logic [7:0] exp_mem [0:2047];
  bit r_e;

  cfg_dma_engine #(.MAX_BURST(MAXB), .SIGNATURE(TB_SIG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr), .reg_size_i(reg_size),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .reg_err_o(reg_err), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_len_o(mem_len),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .mem_err_i(mem_err),
    .key_load_o(key_load), .key_o(key), .off_inc_o(off_inc), .off_step_o(off_step),
    .item_ok_i(sk < 16'd8 && ilen(sk) != 0), .item_len_i(ilen(sk)), .item_off_i(so),
    .item_data_i(item_data)
  );

  function automatic logic [31:0] ilen(input logic [15:0] k);
    return (k < 16'd8) ? 32'(k) * 32'd5 : 32'd0;
  endfunction
  function automatic logic [7:0] dbyte(input logic [15:0] k, input logic [31:0] o);
    return 8'(32'(k) * 37 + o * 11 + 1);
  endfunction
  function automatic bit in_err(input logic [63:0] a);
    return a[63:11] != '0 || a[10:8] == 3'h7;
  endfunction

  always_comb
    for (int i = 0; i < MAXB; i++) item_data[8*i +: 8] = dbyte(sk, so + 32'(i));

  // item store model
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin sk <= '0; so <= '0; end
    else if (key_load) begin sk <= key; so <= '0; end
    else if (off_inc) so <= so + off_step;

  // memory responder
  always @(negedge clk) begin
    if (mem_ack) begin mem_ack = 0; mem_err = 0; end
    else if (mem_req) begin
      if (mem_we && (mem_len == 0 || 32'(mem_len) > MAXB)) burst_bad++;
      if (!mem_we) fetch_addr = mem_addr;
      if (dly > 0) dly--;
      else begin
        r_e = 0;
        if (mem_we) begin
          for (int i = 0; i < 32'(mem_len); i++) if (in_err(mem_addr + 64'(i))) r_e = 1;
          if (!r_e) for (int i = 0; i < 32'(mem_len); i++) mem[10'(0) + 11'(mem_addr + 64'(i))] = mem_wdata[8*i +: 8];
          nwr++;
        end else begin
          for (int i = 0; i < 16; i++) if (in_err(mem_addr + 64'(i))) r_e = 1;
          for (int i = 0; i < 16; i++) mem_rdata[8*i +: 8] = r_e ? 8'h0 : mem[11'(mem_addr + 64'(i))];
        end
        mem_err = r_e;
        mem_ack = 1;
        dly = $urandom % 3;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [3:0] s, input logic [63:0] d, output bit e);
    reg_addr = a; reg_size = s; reg_wdata = d; reg_wr = 1;
    #1 e = reg_err;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, input logic [3:0] s, output logic [63:0] d, output bit e);
    reg_addr = a; reg_size = s; reg_rd = 1;
    #1 begin d = reg_rdata; e = reg_err; end
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    int c = 0;
    while (busy && c < 5000) begin @(negedge clk); c++; end
    chk(c < 5000, "R11 timeout", 64'(c), 64'd5000);
  endtask

  // reference model on exp_mem, from the current store state
  task automatic model(input logic [63:0] d, output bit st, output logic [15:0] k, output logic [31:0] o);
    logic [63:0] ta; logic [31:0] ln, c, rem, av, n; bit rd, sp, fe;
    k = sk; o = so; st = 0; fe = 0;
    for (int i = 0; i < 16; i++) if (in_err(d + 64'(i))) fe = 1;
    if (fe) st = 1;
    else begin
      for (int i = 0; i < 8; i++) ta[63-8*i -: 8] = exp_mem[11'(d + 64'(i))];
      for (int i = 0; i < 4; i++) begin
        ln[31-8*i -: 8] = exp_mem[11'(d + 64'(8 + i))];
        c[31-8*i -: 8]  = exp_mem[11'(d + 64'(12 + i))];
      end
      if (c[3]) begin k = c[31:16]; o = 0; end
      rd = c[1]; sp = !rd && c[2];
      rem = (rd || sp) ? ln : 0;
      while (rem > 0 && !st) begin
        av = (k < 8 && o < ilen(k)) ? ilen(k) - o : 0;
        n = (av > 0 && av < rem) ? av : rem;
        if (rd && in_err(ta)) st = 1;
        else begin
          if (rd) for (int i = 0; i < 32'(n); i++) exp_mem[11'(ta + 64'(i))] = (av > 0) ? dbyte(k, o + 32'(i)) : 8'h0;
          if (av > 0) o = o + n;
          ta = ta + 64'(n); rem = rem - n;
        end
      end
    end
    if (!in_err(d + 64'd8))
      for (int i = 0; i < 4; i++) exp_mem[11'(d + 64'(8 + i))] = (i == 3) ? 8'(st) : 8'h0;
  endtask

  // mode: 0 = 8-byte start, 1 = high then low, 2 = low only
  task automatic run_xfer(input string req, input logic [63:0] d, input logic [63:0] tgt,
                          input logic [31:0] ln, input logic [31:0] c, input int mode, input bit probe);
    bit st, e; logic [15:0] ek; logic [31:0] eo; int bad;
    if (!in_err(d)) begin
      for (int i = 0; i < 8; i++) mem[11'(d + 64'(i))] = tgt[63-8*i -: 8];
      for (int i = 0; i < 4; i++) begin
        mem[11'(d + 64'(8 + i))]  = ln[31-8*i -: 8];
        mem[11'(d + 64'(12 + i))] = c[31-8*i -: 8];
      end
      for (int i = 0; i < 16; i++) exp_mem[11'(d + 64'(i))] = mem[11'(d + 64'(i))];
    end
    model(d, st, ek, eo);
    nwr = 0;
    if (mode == 0) reg_write(3'd0, 4'd8, d, e);
    else begin
      if (mode == 1) reg_write(3'd0, 4'd4, {32'h0, d[63:32]}, e);
      reg_write(3'd4, 4'd4, {32'h0, d[31:0]}, e);
    end
    if (probe) begin
      reg_write(3'd0, 4'd8, 64'h80, e);
      chk(e == 1, "R12 start while busy rejected", 64'(e), 64'd1);
    end
    wait_idle();
    chk(fetch_addr == d, {req, " R1 R3 R4 fetch address"}, fetch_addr, d);
    bad = 0;
    for (int i = 0; i < 2048; i++) if (mem[i] !== exp_mem[i]) begin
      if (bad == 0) $display("FAIL %s R7 R9 R11 memory byte %0h actual=%0h expected=%0h", req, i, mem[i], exp_mem[i]);
      bad++;
    end
    checks++; if (bad != 0) errors++;
    chk(sk == ek && so == eo, {req, " R5 R8 R9 R10 key/offset"}, {sk, so}, {ek, eo});
    if (!c[1]) chk(nwr == 1, {req, " R6 R8 only status write"}, 64'(nwr), 64'd1);
  endtask

  function automatic logic [31:0] ctl(input logic [15:0] k, input bit sel, input bit skip, input bit copy);
    return {k, 12'h0, sel, skip, copy, 1'b0};
  endfunction

  initial begin
    logic [63:0] d; bit e;
    void'($urandom(32'd1234));
    for (int i = 0; i < 2048; i++) begin mem[i] = 8'h5A; exp_mem[i] = 8'h5A; end
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_req == 0, "R12 reset idle", {busy, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);

    reg_read(3'd0, 4'd8, d, e); chk(d == TB_SIG && !e, "R2 read 8@0", d, TB_SIG);
    reg_read(3'd4, 4'd4, d, e); chk(d == 64'h5566_7788, "R2 read 4@4", d, 64'h5566_7788);
    reg_read(3'd3, 4'd1, d, e); chk(d == 64'h44, "R2 read 1@3", d, 64'h44);
    reg_read(3'd6, 4'd2, d, e); chk(d == 64'h7788, "R2 read 2@6", d, 64'h7788);
    reg_read(3'd6, 4'd4, d, e); chk(d == 0 && e, "R2 read outside window", {d[62:0], e}, 1);

    reg_write(3'd0, 4'd2, 64'h10, e); chk(e == 1, "R1 2-byte write rejected", 64'(e), 1);
    @(negedge clk); chk(busy == 0, "R1 rejected write starts nothing", 64'(busy), 0);
    reg_write(3'd2, 4'd4, 64'h10, e); chk(e == 1, "R1 write at offset 2 rejected", 64'(e), 1);
    @(negedge clk); chk(busy == 0, "R1 rejected write starts nothing", 64'(busy), 0);

    run_xfer("R7 full item",      64'h40, 64'h100, 32'd15, ctl(16'd3, 1, 0, 1), 0, 1);
    run_xfer("R9 past end fill",  64'h10, 64'h200, 32'd40, ctl(16'd2, 1, 0, 1), 2, 0);
    run_xfer("R8 skip part",      64'h20, 64'h300, 32'd7,  ctl(16'd5, 1, 1, 0), 1, 0);
    run_xfer("R7 continue copy",  64'h30, 64'h300, 32'd30, ctl(16'd0, 0, 0, 1), 0, 0);
    run_xfer("R6 neither bit",    64'h50, 64'h400, 32'd20, ctl(16'd6, 1, 0, 0), 0, 0);
    run_xfer("R6 copy over skip", 64'h60, 64'h400, 32'd12, ctl(16'd7, 1, 1, 1), 0, 0);
    run_xfer("R9 invalid key",    64'h70, 64'h480, 32'd11, ctl(16'd9, 1, 0, 1), 0, 0);
    run_xfer("R9 skip exhausted", 64'h80, 64'h500, 32'd9,  ctl(16'd0, 1, 1, 0), 0, 0);
    run_xfer("R10 data error",    64'h90, 64'h710, 32'd6,  ctl(16'd4, 1, 0, 1), 0, 0);
    run_xfer("R10 fetch error",   64'h700, 64'h0,  32'd0,  32'h0,               0, 0);
    run_xfer("R1 high address",   64'h1_0000_0020, 64'h0, 32'd0, 32'h0,        1, 0);
    run_xfer("R3 low-only start", 64'hA0, 64'h520, 32'd5,  ctl(16'd1, 1, 0, 1), 2, 1);

    for (int t = 0; t < 30; t++) begin
      logic [63:0] tg;
      tg = ($urandom % 8 == 0) ? 64'h700 + 64'($urandom % 128) : 64'h100 + 64'($urandom % 32'h500);
      run_xfer("R7 R8 R9 random", 64'(($urandom % 16) * 16), tg, 32'($urandom % 61),
               ctl(16'($urandom % 10), 1'($urandom), 1'($urandom), 1'($urandom)),
               int'($urandom % 3), 1'($urandom));
    end

    chk(burst_bad == 0, "R13 burst length within limit", 64'(burst_bad), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule